// File: doc/BRIEF.md
# Cluster Reset Controller

This block turns the raw, active-low reset requests of a small multi-core cluster into clean per-domain resets. Each core has two domains. The functional domain is cleared by a warm or a cold request. The debug/trace domain is cleared only by a cold (power-on) request. Two further domains are shared by the whole cluster: the level-2 memory system together with its snoop-control logic, and the debug logic that runs on a separate APB clock. A test-mode reset request overrides all of them.

Every output drops at once when its request goes low, even if the clock is stopped. Each output is released only after a three-flop synchronizer on its own clock has filled with ones. Each core output has its own synchronizer, so any core can leave reset independently of the others.

A checker samples all request inputs through two flops on the cluster clock. It raises a flag whenever the sampled pattern is not one of the permitted reset combinations.

Top module: `clu_rst_ctrl`

## Requirements
- R1: When any request that feeds an output goes low, that output goes low at once, with no clock edge needed.
- R2: After every request feeding an output is high, the output stays low through two rising edges of its clock and goes high at the third.
- R3: A low `cold_req_n[i]` holds both `core_fn_rst_n[i]` and `core_dbg_rst_n[i]` low.
- R4: A low `warm_req_n[i]` while `cold_req_n[i]` is high holds `core_fn_rst_n[i]` low and leaves `core_dbg_rst_n[i]` high.
- R5: `apb_dom_rst_n` is timed by `clk_apb` and is driven only by `dbg_req_n` and `test_req_n`. The core and L2 requests do not affect it.
- R6: `l2_dom_rst_n` is driven only by `l2_req_n` and `test_req_n`.
- R7: A low `test_req_n` holds every output reset low.
- R8: `bad_combo` is 0, three `clk_core` edges after the inputs settle, for these patterns (every input not listed is high, and warm requests do not matter for any core whose cold request is low):
  - all cold requests low and `l2_req_n` low, with `dbg_req_n` either level;
  - exactly one cold request low;
  - exactly one warm request low;
  - only `dbg_req_n` low;
  - only `test_req_n` low;
  - all inputs high.
- R9: Any other pattern sets `bad_combo` to 1 three `clk_core` edges after the inputs settle.
- R10: Releasing one core's cold request leaves the other cores' outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Cluster clock for the core and L2 domains and for the checker |
| clk_apb | input | 1 | Clock of the debug APB domain |
| cold_req_n | input | NCORE | Per-core power-on reset request, active low |
| warm_req_n | input | NCORE | Per-core warm reset request, active low |
| dbg_req_n | input | 1 | Cluster debug-logic reset request, active low |
| l2_req_n | input | 1 | Shared L2 and snoop-control reset request, active low |
| test_req_n | input | 1 | Test-mode reset request covering every domain, active low |
| core_fn_rst_n | output | NCORE | Per-core functional-domain reset |
| core_dbg_rst_n | output | NCORE | Per-core debug/trace-domain reset |
| l2_dom_rst_n | output | 1 | L2 domain reset |
| apb_dom_rst_n | output | 1 | Debug APB domain reset |
| bad_combo | output | 1 | Sampled request pattern is outside the permitted set |

## Verification
The release-timing assertions assume that each request changes away from the sampling edge of its clock, so that the sampled history reflects the true level. The bench drives every input on a falling clock edge, or while the clock is halted, to keep within that assumption. The override assertion assumes `test_req_n` is stable across an edge. The bench holds each pattern for several cycles of both clocks before it samples. Random illegal patterns come from a fixed seed and are screened against a bench model of the permitted set.

// File: rtl/clu_rst_ctrl.sv
module clu_rst_ctrl #(
  parameter int NCORE = 4,
  parameter int SYNC_STAGES = 3,
  parameter int CHK_STAGES = 2
) (
  input  logic             clk_core,
  input  logic             clk_apb,
  input  logic [NCORE-1:0] cold_req_n,
  input  logic [NCORE-1:0] warm_req_n,
  input  logic             dbg_req_n,
  input  logic             l2_req_n,
  input  logic             test_req_n,
  output logic [NCORE-1:0] core_fn_rst_n,
  output logic [NCORE-1:0] core_dbg_rst_n,
  output logic             l2_dom_rst_n,
  output logic             apb_dom_rst_n,
  output logic             bad_combo
);
  localparam int VW = 2 * NCORE + 3;

  logic [NCORE-1:0] fn_raw, dbg_raw;
  logic             l2_raw, apb_raw;

  assign fn_raw  = cold_req_n & warm_req_n & {NCORE{test_req_n}};
  assign dbg_raw = cold_req_n & {NCORE{test_req_n}};
  assign l2_raw  = l2_req_n & test_req_n;
  assign apb_raw = dbg_req_n & test_req_n;

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    logic [SYNC_STAGES-1:0] fn_q, dbg_q;

    always_ff @(posedge clk_core or negedge fn_raw[i])
      if (!fn_raw[i]) fn_q <= '0;
      else            fn_q <= {fn_q[SYNC_STAGES-2:0], 1'b1};

    always_ff @(posedge clk_core or negedge dbg_raw[i])
      if (!dbg_raw[i]) dbg_q <= '0;
      else             dbg_q <= {dbg_q[SYNC_STAGES-2:0], 1'b1};

    assign core_fn_rst_n[i]  = fn_q[SYNC_STAGES-1];
    assign core_dbg_rst_n[i] = dbg_q[SYNC_STAGES-1];

    AST_FN_RELEASE_DELAY: assert property (@(posedge clk_core) disable iff (!test_req_n)
      $rose(core_fn_rst_n[i]) |-> $past(fn_raw[i], SYNC_STAGES - 1)); // R2
    AST_COLD_CLEARS_BOTH: assert property (@(posedge clk_core) disable iff (!test_req_n)
      !cold_req_n[i] |-> (!core_fn_rst_n[i] && !core_dbg_rst_n[i])); // R3
    AST_WARM_KEEPS_DBG: assert property (@(posedge clk_core) disable iff (!test_req_n)
      ($fell(core_fn_rst_n[i]) && cold_req_n[i] && $past(core_dbg_rst_n[i])) |-> core_dbg_rst_n[i]); // R4
  end

  logic [SYNC_STAGES-1:0] l2_q;
  always_ff @(posedge clk_core or negedge l2_raw)
    if (!l2_raw) l2_q <= '0;
    else         l2_q <= {l2_q[SYNC_STAGES-2:0], 1'b1};
  assign l2_dom_rst_n = l2_q[SYNC_STAGES-1];

  logic [SYNC_STAGES-1:0] apb_q;
  always_ff @(posedge clk_apb or negedge apb_raw)
    if (!apb_raw) apb_q <= '0;
    else          apb_q <= {apb_q[SYNC_STAGES-2:0], 1'b1};
  assign apb_dom_rst_n = apb_q[SYNC_STAGES-1];

  logic [VW-1:0] smp [CHK_STAGES];
  always_ff @(posedge clk_core) begin
    smp[0] <= {test_req_n, l2_req_n, dbg_req_n, warm_req_n, cold_req_n};
    for (int k = 1; k < CHK_STAGES; k++) smp[k] <= smp[k-1];
  end

  logic [NCORE-1:0] s_cold, s_warm_eff;
  logic             s_dbg, s_l2, s_test;
  int               n_cold, n_warm;
  logic             legal;

  always_comb begin
    s_cold     = smp[CHK_STAGES-1][NCORE-1:0];
    s_warm_eff = smp[CHK_STAGES-1][2*NCORE-1:NCORE] | ~s_cold;
    s_dbg      = smp[CHK_STAGES-1][2*NCORE];
    s_l2       = smp[CHK_STAGES-1][2*NCORE+1];
    s_test     = smp[CHK_STAGES-1][2*NCORE+2];
    n_cold     = $countones(~s_cold);
    n_warm     = $countones(~s_warm_eff);
    legal = (s_test && !s_l2 && n_cold == NCORE)
         || (s_test && s_l2 && s_dbg && n_cold + n_warm <= 1)
         || (s_test && s_l2 && !s_dbg && n_cold == 0 && n_warm == 0)
         || (!s_test && s_l2 && s_dbg && n_cold == 0 && n_warm == 0);
  end
  assign bad_combo = !legal;

  AST_TEST_OVERRIDE: assert property (@(posedge clk_core)
    !test_req_n |-> (core_fn_rst_n == '0 && core_dbg_rst_n == '0 && !l2_dom_rst_n)); // R7
  AST_L2_RELEASE_DELAY: assert property (@(posedge clk_core) disable iff (!test_req_n)
    $rose(l2_dom_rst_n) |-> ($past(l2_raw, SYNC_STAGES - 1) && l2_req_n)); // R6
  AST_APB_RELEASE_DELAY: assert property (@(posedge clk_apb) disable iff (!test_req_n)
    $rose(apb_dom_rst_n) |-> ($past(apb_raw, SYNC_STAGES - 1) && dbg_req_n)); // R5
  AST_FN_IMPLIES_DBG: assert property (@(posedge clk_core) disable iff (!test_req_n)
    (core_fn_rst_n & ~core_dbg_rst_n) == '0); // R4
endmodule

// File: tb/clu_rst_ctrl_tb_top.sv
module clu_rst_ctrl_tb_top;
  localparam int N = 4;

  logic clk_core = 0, clk_apb = 0, clk_en = 1;
  logic [N-1:0] cold_n, warm_n;
  logic dbg_n, l2_n, test_n;
  logic [N-1:0] fn_o, dbgd_o;
  logic l2_o, apb_o, bad_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk_core = clk_en ? ~clk_core : clk_core;
  always #7 clk_apb  = clk_en ? ~clk_apb  : clk_apb;

  clu_rst_ctrl #(.NCORE(N)) dut_i (
    .clk_core(clk_core), .clk_apb(clk_apb), .cold_req_n(cold_n), .warm_req_n(warm_n),
    .dbg_req_n(dbg_n), .l2_req_n(l2_n), .test_req_n(test_n),
    .core_fn_rst_n(fn_o), .core_dbg_rst_n(dbgd_o), .l2_dom_rst_n(l2_o),
    .apb_dom_rst_n(apb_o), .bad_combo(bad_o));

  function automatic bit legal_m(logic [N-1:0] c, logic [N-1:0] w, logic d, logic l, logic t);
    int pz = 0, wz = 0;
    for (int i = 0; i < N; i++) begin
      if (!c[i]) pz++;
      else if (!w[i]) wz++;
    end
    if (!t) return pz == 0 && wz == 0 && d && l;
    if (pz == N) return !l;
    if (!l) return 0;
    if (!d) return pz == 0 && wz == 0;
    return (pz + wz) <= 1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [N-1:0] c, logic [N-1:0] w, logic d, logic l, logic t);
    @(negedge clk_core);
    cold_n = c; warm_n = w; dbg_n = d; l2_n = l; test_n = t;
  endtask

  task automatic settle_and_check(string tag);
    logic [N-1:0] ef, ed;
    repeat (4) @(posedge clk_core);
    repeat (4) @(posedge clk_apb);
    #1;
    ef = cold_n & warm_n & {N{test_n}};
    ed = cold_n & {N{test_n}};
    chk({tag, " R3/R4 fn"}, 32'(fn_o), 32'(ef));
    chk({tag, " R3 dbg"}, 32'(dbgd_o), 32'(ed));
    chk({tag, " R6 l2"}, 32'(l2_o), 32'(l2_n & test_n));
    chk({tag, " R5 apb"}, 32'(apb_o), 32'(dbg_n & test_n));
    chk({tag, (legal_m(cold_n, warm_n, dbg_n, l2_n, test_n) ? " R8 flag" : " R9 flag")},
        32'(bad_o), 32'(!legal_m(cold_n, warm_n, dbg_n, l2_n, test_n)));
  endtask

  localparam logic [N-1:0] ONES = '1;

  initial begin
    void'($urandom(32'd1234));
    cold_n = '0; warm_n = '0; dbg_n = 0; l2_n = 0; test_n = 1;
    #1;
    chk("R3 reset state fn", 32'(fn_o), 0);
    chk("R3 reset state dbg", 32'(dbgd_o), 0);
    settle_and_check("cluster cold");

    // R2: release timing on the core clock
    @(negedge clk_core);
    cold_n = ONES; warm_n = ONES; l2_n = 1;
    repeat (2) @(posedge clk_core);
    #1;
    chk("R2 fn still low after 2 edges", 32'(fn_o), 0);
    chk("R2 l2 still low after 2 edges", 32'(l2_o), 0);
    @(posedge clk_core);
    #1;
    chk("R2 fn high at 3rd edge", 32'(fn_o), 32'(ONES));
    chk("R2 l2 high at 3rd edge", 32'(l2_o), 1);
    // R5/R2: APB domain on its own clock
    @(negedge clk_apb);
    dbg_n = 1;
    repeat (2) @(posedge clk_apb);
    #1;
    chk("R5 apb low after 2 apb edges", 32'(apb_o), 0);
    @(posedge clk_apb);
    #1;
    chk("R5 apb high at 3rd apb edge", 32'(apb_o), 1);
    settle_and_check("normal");

    drive('0, ONES, 1, 0, 1); settle_and_check("cold debug active");
    drive('0, '0, 0, 0, 1);   settle_and_check("cold warm dontcare");
    for (int i = 0; i < N; i++) begin
      drive(ONES, ONES, 1, 1, 1); settle_and_check("normal");
      drive(ONES & ~(N'(1) << i), ONES & ~(N'(1) << i), 1, 1, 1); settle_and_check("single cold");
      // R10: release this core alone, others untouched
      drive(ONES, ONES, 1, 1, 1);
      #1;
      chk("R10 others unchanged", 32'(fn_o | (N'(1) << i)), 32'(ONES));
      settle_and_check("R10 release");
      drive(ONES, ONES & ~(N'(1) << i), 1, 1, 1); settle_and_check("R4 single warm");
      chk("R4 dbg kept", 32'(dbgd_o), 32'(ONES));
    end
    drive(ONES, ONES, 0, 1, 1); settle_and_check("debug only");
    chk("R5 cores untouched", 32'(fn_o), 32'(ONES));
    drive(ONES, ONES, 1, 1, 0); settle_and_check("R7 test");
    chk("R7 apb held", 32'(apb_o), 0);
    drive(ONES, ONES, 1, 0, 1); settle_and_check("R6 l2 alone");
    chk("R5 apb ignores l2", 32'(apb_o), 1);
    drive(ONES, ONES, 1, 1, 1); settle_and_check("normal");

    // R1: clocks stopped, assertion still immediate
    @(negedge clk_core);
    clk_en = 0;
    #20;
    cold_n[1] = 0;
    #2;
    chk("R1 core1 fn drops", 32'(fn_o[1]), 0);
    chk("R1 core1 dbg drops", 32'(dbgd_o[1]), 0);
    chk("R10 core0 stays", 32'(fn_o[0]), 1);
    test_n = 0;
    #2;
    chk("R1 R7 all fn drop", 32'(fn_o), 0);
    chk("R1 R7 l2 drop", 32'(l2_o), 0);
    chk("R1 R7 apb drop", 32'(apb_o), 0);
    clk_en = 1;
    drive(ONES, ONES, 1, 1, 1); settle_and_check("restart");

    // random patterns, both legal and illegal
    for (int k = 0; k < 60; k++) begin
      logic [N-1:0] c, w;
      logic d, l, t;
      c = N'($urandom); w = N'($urandom);
      d = 1'($urandom); l = 1'($urandom); t = ($urandom % 4) != 0;
      drive(c, w, d, l, t);
      settle_and_check(legal_m(c, w, d, l, t) ? "rand legal" : "rand illegal");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule